// File: doc/BRIEF.md
# External Interrupt Trigger Qualifier

This block sits between eight external interrupt pins and an interrupt controller. Each pin has a 2-bit trigger mode. The mode picks one of four behaviours: active-low level, active-high level, rising edge or falling edge. The block resynchronises every pin into the system clock domain. It then turns the pin activity into a per-pin request strobe, which the controller latches as a pending request. The block does not store requests and does not resolve priority.

The modes sit in two byte-wide configuration registers, with four pins per byte. Software reaches these registers through a small byte port: an address, a write enable, write data and a combinational read path. Both level modes assert the strobe on every cycle the synchronised pin is at its active level. Both edge modes give exactly one strobe cycle for each selected transition.

Top module: `xint_qualify`

## Requirements
- R1: Mode code per pin: 0 = active low, 1 = active high, 2 = rising edge, 3 = falling edge. Configuration offset 0 holds pins 0..3 and offset 1 holds pins 4..7. Pin k within a byte uses bits [2k+1:2k].
- R2: After reset every pin is in falling-edge mode, so offsets 0 and 1 read 0xFF, and no strobe is asserted.
- R3: In active-high mode, `req_o[i]` is 1 on every cycle whose synchronised pin value is 1, and 0 otherwise.
- R4: In active-low mode, `req_o[i]` is 1 on every cycle whose synchronised pin value is 0, and 0 otherwise.
- R5: In rising-edge mode, each 0-to-1 transition of the synchronised pin gives exactly one strobe cycle, and nothing else gives a strobe.
- R6: In falling-edge mode, each 1-to-0 transition of the synchronised pin gives exactly one strobe cycle, and nothing else gives a strobe.
- R7: A read at offset 0 or 1 returns the four packed modes of that byte, in the layout of R1.
- R8: Reads at offsets 2 and 3 return 0. Writes to those offsets change no mode.
- R9: A mode write is used for the first strobe decision after the write edge. Changing the mode while a pin is steady never produces an edge strobe.
- R10: Pin latency is fixed. A value applied before clock edge n affects `req_o` after edge n+2: two synchroniser flops plus the strobe register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 8 | Raw external interrupt pins, asynchronous |
| cfg_addr_i | input | 2 | Configuration byte offset |
| cfg_we_i | input | 1 | Write strobe for the configuration port |
| cfg_wdata_i | input | 8 | Write data |
| cfg_rdata_o | output | 8 | Combinational read data for `cfg_addr_i` |
| req_o | output | 8 | Per-pin request strobe, one bit per pin |

## Verification
The bench keeps a history of pin samples and a model of the mode bytes, then predicts every strobe bit on every clock. A design that shortens or lengthens the synchroniser shows up at once as a one-cycle offset. So does one that decodes the strobe from the raw pin. Each pin gets its own mode, and pin values are randomised. This exposes a swapped mode code or a wrong field position: one pin would pulse on the wrong edge or stay asserted as a level.

Modes are rewritten while the pins are held steady. A detector that derives "previous" from the mode or resets its history on a write would emit a spurious pulse there. Writes to the two unmapped offsets are checked through readback. A decoder that ignores the upper address bit would alias them onto the real bytes.

// File: rtl/xint_pkg.sv
package xint_pkg;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_FALL = 2'd3
  } trig_mode_e;

  localparam int unsigned MODE_W     = $bits(trig_mode_e);
  localparam trig_mode_e  TRIG_RESET = TRIG_FALL;

  // Strobe decision for one pin from its current and previous synchronised value.
  function automatic logic trig_fires(trig_mode_e mode, logic cur, logic prev);
    logic hit;
    case (mode)
      TRIG_LOW:  hit = ~cur;
      TRIG_HIGH: hit = cur;
      TRIG_RISE: hit = cur & ~prev;
      default:   hit = ~cur & prev;
    endcase
    return hit;
  endfunction

  // Lowest bit of a pin's field inside its configuration byte.
  function automatic int unsigned field_lsb(int unsigned pin, int unsigned pins_per_byte);
    return (pin % pins_per_byte) * MODE_W;
  endfunction

endpackage

// File: rtl/xint_sync.sv
module xint_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < int'(STAGES); s++) chain[s] <= '0;
    end else begin
      chain[0] <= d_i;
      for (int s = 1; s < int'(STAGES); s++) chain[s] <= chain[s-1];
    end
  end

  assign q_o = chain[STAGES-1];

endmodule

// File: rtl/xint_mode_regs.sv
module xint_mode_regs
  import xint_pkg::*;
#(
  parameter int unsigned N_PINS = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic [DATA_W-1:0]        rdata_o,
  output logic [N_PINS*MODE_W-1:0] mode_vec_o
);

  localparam int unsigned PPB = DATA_W / MODE_W;

  for (genvar i = 0; i < int'(N_PINS); i++) begin : g_pin
    localparam int unsigned BYTE_IDX = i / PPB;
    localparam int unsigned LSB      = field_lsb(i, PPB);
    trig_mode_e mode_q;
    logic       sel;

    assign sel = we_i && (addr_i == ADDR_W'(BYTE_IDX));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mode_q <= TRIG_RESET;
      else if (sel) mode_q <= trig_mode_e'(wdata_i[LSB +: MODE_W]);
    end

    assign mode_vec_o[i*MODE_W +: MODE_W] = mode_q;
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < int'(N_PINS); i++) begin
      if (addr_i == ADDR_W'(i / int'(PPB)))
        rdata_o[(i % int'(PPB))*MODE_W +: MODE_W] = mode_vec_o[i*MODE_W +: MODE_W];
    end
  end

endmodule

// File: rtl/xint_detect.sv
module xint_detect
  import xint_pkg::*;
#(
  parameter int unsigned N_PINS = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_PINS-1:0]        lvl_i,
  input  logic [N_PINS*MODE_W-1:0] mode_vec_i,
  output logic [N_PINS-1:0]        prev_o,
  output logic [N_PINS-1:0]        req_o
);

  logic [N_PINS-1:0] prev_q;
  logic [N_PINS-1:0] fire;
  logic [N_PINS-1:0] req_q;

  for (genvar i = 0; i < int'(N_PINS); i++) begin : g_pin
    trig_mode_e mode;
    assign mode    = trig_mode_e'(mode_vec_i[i*MODE_W +: MODE_W]);
    assign fire[i] = trig_fires(mode, lvl_i[i], prev_q[i]);
  end

  // History follows the pin alone; a mode write never touches it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      req_q  <= '0;
    end else begin
      prev_q <= lvl_i;
      req_q  <= fire;
    end
  end

  assign prev_o = prev_q;
  assign req_o  = req_q;

endmodule

// File: rtl/xint_qualify.sv
module xint_qualify
  import xint_pkg::*;
#(
  parameter int unsigned N_PINS      = 8,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic              cfg_we_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [DATA_W-1:0] cfg_rdata_o,
  output logic [N_PINS-1:0] req_o
);

  // Named internal events, observed by the bound checker.
  logic [N_PINS*MODE_W-1:0] mode_vec;
  logic [N_PINS-1:0]        sync_lvl;
  logic [N_PINS-1:0]        sync_prev;

  xint_mode_regs #(
    .N_PINS (N_PINS),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .we_i       (cfg_we_i),
    .addr_i     (cfg_addr_i),
    .wdata_i    (cfg_wdata_i),
    .rdata_o    (cfg_rdata_o),
    .mode_vec_o (mode_vec)
  );

  xint_sync #(
    .W      (N_PINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_i),
    .q_o   (sync_lvl)
  );

  xint_detect #(
    .N_PINS (N_PINS)
  ) u_detect (
    .clk        (clk),
    .rst_n      (rst_n),
    .lvl_i      (sync_lvl),
    .mode_vec_i (mode_vec),
    .prev_o     (sync_prev),
    .req_o      (req_o)
  );

endmodule

// File: rtl/xint_qualify_chk.sv
module xint_qualify_chk #(
  parameter int unsigned N_PINS = 8,
  parameter int unsigned ADDR_W = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cfg_we_i,
  input logic [ADDR_W-1:0]     cfg_addr_i,
  input logic [N_PINS*2-1:0]   mode_vec,
  input logic [N_PINS-1:0]     sync_lvl,
  input logic [N_PINS-1:0]     sync_prev,
  input logic [N_PINS-1:0]     req_o
);

  localparam int unsigned N_BYTES = (N_PINS + 3) / 4;

  p_reset_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (req_o == '0));

  p_unmapped_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we_i && (cfg_addr_i >= ADDR_W'(N_BYTES))) |=> $stable(mode_vec));

  for (genvar i = 0; i < int'(N_PINS); i++) begin : g_pin
    p_high_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode_vec[i*2 +: 2]) == 2'd1) |-> (req_o[i] == $past(sync_lvl[i])));

    p_low_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode_vec[i*2 +: 2]) == 2'd0) |-> (req_o[i] == !$past(sync_lvl[i])));

    p_rise_needs_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(mode_vec[i*2 +: 2]) == 2'd2) && req_o[i])
        |-> ($past(sync_lvl[i]) && !$past(sync_prev[i])));

    p_fall_needs_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(mode_vec[i*2 +: 2]) == 2'd3) && req_o[i])
        |-> (!$past(sync_lvl[i]) && $past(sync_prev[i])));

    p_steady_no_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(mode_vec[i*2 +: 2]) >= 2'd2) && ($past(sync_lvl[i]) == $past(sync_prev[i])))
        |-> !req_o[i]);
  end

endmodule

bind xint_qualify xint_qualify_chk #(
  .N_PINS (N_PINS),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we_i   (cfg_we_i),
  .cfg_addr_i (cfg_addr_i),
  .mode_vec   (mode_vec),
  .sync_lvl   (sync_lvl),
  .sync_prev  (sync_prev),
  .req_o      (req_o)
);

// File: tb/xint_qualify_tb.sv
module xint_qualify_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin_i = 8'h00;
  logic [1:0] cfg_addr_i = 2'd0;
  logic       cfg_we_i = 1'b0;
  logic [7:0] cfg_wdata_i = 8'h00;
  logic [7:0] cfg_rdata_o;
  logic [7:0] req_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk; // 125 MHz

  xint_qualify u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_i       (pin_i),
    .cfg_addr_i  (cfg_addr_i),
    .cfg_we_i    (cfg_we_i),
    .cfg_wdata_i (cfg_wdata_i),
    .cfg_rdata_o (cfg_rdata_o),
    .req_o       (req_o)
  );

  // ---------------- reference model ----------------
  int   mdl_mode [8];
  bit   hist [$][8];   // hist[0] newest pin sample
  logic [7:0] exp_req = 8'h00;
  int   since_write = 100;
  int   strobe_count = 0;

  function automatic bit fires(int m, bit cur, bit prev);
    if (m == 0) return !cur;
    if (m == 1) return cur;
    if (m == 2) return cur && !prev;
    return !cur && prev;
  endfunction

  function automatic string tag_for(int m, int sw);
    if (sw <= 1) return "R9";
    if (m == 0) return "R4";
    if (m == 1) return "R3";
    if (m == 2) return "R5";
    return "R6";
  endfunction

  task automatic model_reset();
    bit z [8];
    foreach (z[k]) z[k] = 0;
    hist.delete();
    for (int s = 0; s < 3; s++) hist.push_back(z);
    foreach (mdl_mode[k]) mdl_mode[k] = 3;
    exp_req = 8'h00;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) begin
      model_reset();
    end else begin
      bit smp [8];
      // R10: strobe from sample two edges back and the one before it
      for (int k = 0; k < 8; k++)
        exp_req[k] = fires(mdl_mode[k], hist[1][k], hist[2][k]);
      since_write++;
      if (cfg_we_i && cfg_addr_i < 2) begin
        for (int k = 0; k < 4; k++)
          mdl_mode[cfg_addr_i*4 + k] = int'(cfg_wdata_i[2*k +: 2]);
        since_write = 0;
      end
      for (int k = 0; k < 8; k++) smp[k] = pin_i[k];
      hist.push_front(smp);
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      strobe_count += $countones(req_o);
      if (req_o !== exp_req) begin
        int bad = 0;
        for (int k = 7; k >= 0; k--) if (req_o[k] !== exp_req[k]) bad = k;
        failures++;
        $display("FAIL %s (R10) pin %0d: req_o actual=%h expected=%h",
                 tag_for(mdl_mode[bad], since_write), bad, req_o, exp_req);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_addr_i = a; cfg_wdata_i = d; cfg_we_i = 1'b1;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic rd_check(input logic [1:0] a, input logic [7:0] e, input string req);
    @(negedge clk);
    cfg_addr_i = a;
    #1;
    checks++;
    if (cfg_rdata_o !== e) begin
      failures++;
      $display("FAIL %s read offset %0d: actual=%h expected=%h", req, a, cfg_rdata_o, e);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_val(input int act, input int e, input string what);
    checks++;
    if (act != e) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, e);
    end
  endtask

  // ---------------- test sequence ----------------
  initial begin
    int c0;
    hold(3);
    rst_n = 1'b1;
    // R2: reset defaults, falling-edge everywhere
    rd_check(2'd0, 8'hFF, "R2");
    rd_check(2'd1, 8'hFF, "R2");
    check_val(int'(req_o), 0, "R2 strobes after reset");

    // R6: one falling pulse per pin under default mode
    pin_i = 8'hFF; hold(6);
    c0 = strobe_count;
    pin_i = 8'h00; hold(6);
    check_val(strobe_count - c0, 8, "R6 single falling strobe per pin");

    // R1/R7: mixed modes, pin k of a byte at bits [2k+1:2k]
    wr(2'd0, 8'hE4); // pin0 low, pin1 high, pin2 rise, pin3 fall
    wr(2'd1, 8'h1B); // pin4 fall, pin5 rise, pin6 high, pin7 low
    rd_check(2'd0, 8'hE4, "R7");
    rd_check(2'd1, 8'h1B, "R1");

    // R3/R4/R5/R6: random pin activity compared every cycle
    for (int n = 0; n < 400; n++) begin
      pin_i = 8'($urandom);
      hold(1 + int'($urandom % 4));
    end

    // R5: isolated rising pulse on pin2 only
    pin_i = 8'h00; hold(6);
    c0 = strobe_count;
    wr(2'd0, 8'hAA); wr(2'd1, 8'hAA); // all rising
    hold(4);
    c0 = strobe_count;
    pin_i = 8'h04; hold(6);
    check_val(strobe_count - c0, 1, "R5 one strobe for one rise");

    // R8: unmapped offsets read 0 and ignore writes
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h55);
    rd_check(2'd2, 8'h00, "R8");
    rd_check(2'd3, 8'h00, "R8");
    rd_check(2'd0, 8'hAA, "R8");
    rd_check(2'd1, 8'hAA, "R8");

    // R9: steady pins, edge modes swapped, no strobe
    pin_i = 8'hA5; hold(6);
    c0 = strobe_count;
    wr(2'd0, 8'hFF); wr(2'd1, 8'hFF);
    wr(2'd0, 8'hAA); wr(2'd1, 8'hFF);
    hold(4);
    check_val(strobe_count - c0, 0, "R9 mode change while steady");

    // R3: active-high on all pins, 10 cycles at 1 gives 10 strobes each
    wr(2'd0, 8'h55); wr(2'd1, 8'h55);
    pin_i = 8'h00; hold(5);
    c0 = strobe_count;
    pin_i = 8'hFF; hold(10);
    pin_i = 8'h00; hold(5);
    check_val(strobe_count - c0, 80, "R3 level strobes every active cycle");

    // R4 and R9: switch to active-low with pins low, strobes start next cycle
    c0 = strobe_count;
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    hold(6);
    check_val(int'(req_o), 255, "R4 active-low with pins low");

    for (int n = 0; n < 200; n++) begin
      pin_i = 8'($urandom);
      if (n % 25 == 0) wr(2'(n % 2), 8'($urandom));
      hold(1 + int'($urandom % 3));
    end

    hold(4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule